// File: doc/BRIEF.md
# Flash Program/Erase Status Responder

This block is the device-side status engine of a 16-bit-wide NOR flash array. It sits between the bus interface and a behavioural model of the cell array. Decoded program-start and erase-start events come in from the command decoder, and an internal cycle counter models how long each operation runs. While an operation is in flight, the block shapes read data so that a host can poll for completion. It also drives an active-low busy indication and obeys a dedicated active-low flash reset.

A host has three ways to detect completion, and all three work at once. The first is a polled bit 7 that reads as the inverse of the last programmed value, or as 0 during an erase. The second is a bit 6 that flips on every read while an operation runs. The third is a busy pull-down enable that stays asserted for the whole operation. Once the operation ends, reads return true array data again. Pulling the flash reset low abandons the operation, turns off the data drivers and releases the busy line. One clock after the flash reset is released, the device is back in read mode.

Top module: `flash_status_responder`

## Requirements
- R1: While `rst_ni` is low and directly after it is released, the block is in read mode: `dq_oe_o`=1, `busy_pd_o`=0, `dq_o`=0.
- R2: In read mode, a read (`rd_en_i`=1) sampled at a clock edge loads `dq_o` with the array word for `rd_addr_i` at that edge. Without a read, `dq_o` holds its value.
- R3: During a program operation, a read returns a status word: bit 7 = inverse of bit 7 of the programmed word, bit 6 = toggle bit, and all other bits 0.
- R4: During an erase operation, a status read returns bit 7 = 0, with bit 6 as the toggle bit and all other bits 0.
- R5: The toggle bit (bit 6) is 0 after `rst_ni`. It inverts after every read made during an operation, and it is left unchanged by reads in read mode.
- R6: A start accepted in read mode asserts `busy_pd_o` from the next edge for exactly PROG_CYCLES (program) or ERASE_CYCLES (erase) clock cycles. The block then returns to read mode.
- R7: Start events that arrive while an operation runs are ignored and do not change its length or status.
- R8: While `frst_ni` is low, the next edge stops any operation and forces `dq_oe_o`=0, `busy_pd_o`=0 and `dq_o`=0. Reads and starts are ignored.
- R9: At the first edge with `frst_ni` high after a halt, the block enters read mode (`dq_oe_o`=1, `dq_o`=0). Reads and starts at that edge are ignored.
- R10: `arr_addr_o` equals `rd_addr_i` at all times. Its bit 0 is the lowest word-address line, because the array is addressed by 16-bit word.
- R11: If program and erase starts arrive at the same edge in read mode, the program operation is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| frst_ni | input | 1 | Dedicated active-low flash reset |
| prog_start_i | input | 1 | Decoded program start event |
| erase_start_i | input | 1 | Decoded erase start event |
| wr_data_i | input | 16 | Word being programmed, captured at program start |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 19 | Word address of the read |
| arr_addr_o | output | 19 | Word address forwarded to the array model |
| arr_data_i | input | 16 | Array word for `arr_addr_o` |
| dq_o | output | 16 | Registered read data |
| dq_oe_o | output | 1 | Data driver enable (0 = high impedance) |
| busy_pd_o | output | 1 | Busy pull-down enable (1 = line driven low, 0 = released) |

## Verification
Every registered result is due one edge after the inputs are sampled. A read, a start, a flash-reset assertion or a flash-reset release sampled at edge N changes `dq_o`, `busy_pd_o` or `dq_oe_o` after edge N. `busy_pd_o` then falls after edge N+PROG_CYCLES or N+ERASE_CYCLES. `arr_addr_o` is combinational and is checked within the same cycle. The bench drives inputs on the falling edge, advances its reference model on the rising edge, and compares all outputs on the following falling edge, so each expected value lines up with the edge that produced it.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int unsigned DQ_W     = 16;
  localparam int unsigned ADDR_W   = 19;
  localparam int unsigned POLL_BIT = 7;
  localparam int unsigned TOG_BIT  = 6;

  typedef enum logic [1:0] {
    MODE_READ  = 2'd0,
    MODE_PROG  = 2'd1,
    MODE_ERASE = 2'd2,
    MODE_HALT  = 2'd3
  } mode_e;
endpackage

// File: rtl/fsr_op_timer.sv
module fsr_op_timer #(
  parameter int unsigned PROG_CYCLES  = 6,
  parameter int unsigned ERASE_CYCLES = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_prog_i,
  input  logic load_erase_i,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int unsigned CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_prog_i) begin
      cnt_q <= CNT_W'(PROG_CYCLES - 1);
    end else if (load_erase_i) begin
      cnt_q <= CNT_W'(ERASE_CYCLES - 1);
    end else if (run_i && cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign done_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/fsr_mode_ctl.sv
module fsr_mode_ctl
  import fsr_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  frst_ni,
  input  logic  prog_start_i,
  input  logic  erase_start_i,
  input  logic  done_i,
  output mode_e mode_o,
  output logic  load_prog_o,
  output logic  load_erase_o
);
  mode_e mode_q, mode_d;

  assign load_prog_o  = frst_ni && (mode_q == MODE_READ) && prog_start_i;
  assign load_erase_o = frst_ni && (mode_q == MODE_READ) && erase_start_i && !prog_start_i;

  always_comb begin
    mode_d = mode_q;
    if (!frst_ni) begin
      mode_d = MODE_HALT;
    end else begin
      unique case (mode_q)
        MODE_READ: begin
          if (load_prog_o)       mode_d = MODE_PROG;
          else if (load_erase_o) mode_d = MODE_ERASE;
        end
        MODE_PROG, MODE_ERASE: if (done_i) mode_d = MODE_READ;
        MODE_HALT: mode_d = MODE_READ;
        default:   mode_d = MODE_READ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_READ;
    else         mode_q <= mode_d;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/fsr_read_path.sv
module fsr_read_path
  import fsr_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            frst_ni,
  input  mode_e           mode_i,
  input  logic            rd_en_i,
  input  logic            load_prog_i,
  input  logic            load_erase_i,
  input  logic [DQ_W-1:0] wr_data_i,
  input  logic [DQ_W-1:0] arr_data_i,
  output logic [DQ_W-1:0] dq_o
);
  logic            poll_q;
  logic            tog_q;
  logic [DQ_W-1:0] dq_q;
  logic [DQ_W-1:0] status;
  logic            busy;

  assign busy = (mode_i == MODE_PROG) || (mode_i == MODE_ERASE);

  always_comb begin
    status           = '0;
    status[POLL_BIT] = poll_q;
    status[TOG_BIT]  = tog_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      poll_q <= 1'b0;
    end else if (load_prog_i) begin
      poll_q <= ~wr_data_i[POLL_BIT];
    end else if (load_erase_i) begin
      poll_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dq_q  <= '0;
      tog_q <= 1'b0;
    end else if (!frst_ni || mode_i == MODE_HALT) begin
      dq_q <= '0;
    end else if (rd_en_i) begin
      dq_q <= busy ? status : arr_data_i;
      if (busy) tog_q <= ~tog_q;
    end
  end

  assign dq_o = dq_q;
endmodule

// File: rtl/flash_status_responder.sv
module flash_status_responder
  import fsr_pkg::*;
#(
  parameter int unsigned PROG_CYCLES  = 6,
  parameter int unsigned ERASE_CYCLES = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frst_ni,
  input  logic              prog_start_i,
  input  logic              erase_start_i,
  input  logic [DQ_W-1:0]   wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [ADDR_W-1:0] arr_addr_o,
  input  logic [DQ_W-1:0]   arr_data_i,
  output logic [DQ_W-1:0]   dq_o,
  output logic              dq_oe_o,
  output logic              busy_pd_o
);
  mode_e mode_q;
  logic  load_prog, load_erase, op_done, busy;

  assign busy = (mode_q == MODE_PROG) || (mode_q == MODE_ERASE);

  fsr_mode_ctl u_mode (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frst_ni      (frst_ni),
    .prog_start_i (prog_start_i),
    .erase_start_i(erase_start_i),
    .done_i       (op_done),
    .mode_o       (mode_q),
    .load_prog_o  (load_prog),
    .load_erase_o (load_erase)
  );

  fsr_op_timer #(
    .PROG_CYCLES (PROG_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES)
  ) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_prog_i (load_prog),
    .load_erase_i(load_erase),
    .run_i       (busy),
    .done_o      (op_done)
  );

  fsr_read_path u_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frst_ni     (frst_ni),
    .mode_i      (mode_q),
    .rd_en_i     (rd_en_i),
    .load_prog_i (load_prog),
    .load_erase_i(load_erase),
    .wr_data_i   (wr_data_i),
    .arr_data_i  (arr_data_i),
    .dq_o        (dq_o)
  );

  assign arr_addr_o = rd_addr_i;
  assign dq_oe_o    = (mode_q != MODE_HALT);
  assign busy_pd_o  = busy;
endmodule

// File: rtl/flash_status_responder_chk.sv
module flash_status_responder_chk
  import fsr_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            frst_ni,
  input logic            prog_start_i,
  input logic            rd_en_i,
  input logic [DQ_W-1:0] dq_o,
  input logic            dq_oe_o,
  input logic            busy_pd_o,
  input mode_e           mode_i
);
  a_r6_busy_after_prog: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frst_ni && dq_oe_o && !busy_pd_o && prog_start_i) |=> busy_pd_o);

  a_r8_halt_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frst_ni |=> (!dq_oe_o && !busy_pd_o && dq_o == '0));

  a_r9_release_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frst_ni && !dq_oe_o) |=> (dq_oe_o && !busy_pd_o));

  a_r2_dq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frst_ni && dq_oe_o && !rd_en_i) |=> $stable(dq_o));

  a_r4_erase_poll_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frst_ni && rd_en_i && mode_i == MODE_ERASE) |=> !dq_o[POLL_BIT]);
endmodule

bind flash_status_responder flash_status_responder_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .frst_ni     (frst_ni),
  .prog_start_i(prog_start_i),
  .rd_en_i     (rd_en_i),
  .dq_o        (dq_o),
  .dq_oe_o     (dq_oe_o),
  .busy_pd_o   (busy_pd_o),
  .mode_i      (mode_q)
);

// File: tb/flash_status_responder_tb.sv
`timescale 1ns/1ps
module flash_status_responder_tb;
  localparam int P = 6;
  localparam int E = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frst_n = 1'b1;
  logic        prog_start = 1'b0, erase_start = 1'b0, rd_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [18:0] rd_addr = '0;
  logic [18:0] arr_addr;
  logic [15:0] arr_data, dq;
  logic        dq_oe, busy_pd;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  function automatic logic [15:0] arr_f(logic [18:0] a);
    return a[15:0] ^ {a[18:16], 13'h1A5C};
  endfunction
  assign arr_data = arr_f(arr_addr);

  flash_status_responder #(.PROG_CYCLES(P), .ERASE_CYCLES(E)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .frst_ni(frst_n),
    .prog_start_i(prog_start), .erase_start_i(erase_start), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .arr_addr_o(arr_addr), .arr_data_i(arr_data),
    .dq_o(dq), .dq_oe_o(dq_oe), .busy_pd_o(busy_pd));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model: 0 read, 1 program, 2 erase, 3 halted
  int          m_mode = 0, m_rem = 0;
  logic        m_tog = 0, m_b7 = 0, m_stat = 0;
  logic [15:0] m_dq = '0;
  string       m_dq_tag = "R1", m_oe_tag = "R1", m_busy_tag = "R1", m_op_tag = "R3";
  bit          m_live = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_rem = 0; m_tog = 0; m_b7 = 0; m_dq = '0; m_stat = 0;
      m_dq_tag = "R1"; m_oe_tag = "R1"; m_busy_tag = "R1";
    end else begin
      bit busy;
      busy = (m_mode == 1) || (m_mode == 2);
      m_stat = 0;
      if (!frst_n) begin
        m_mode = 3; m_dq = '0;
        m_dq_tag = "R8"; m_oe_tag = "R8"; m_busy_tag = "R8";
      end else if (m_mode == 3) begin
        m_mode = 0; m_dq = '0;
        m_dq_tag = "R9"; m_oe_tag = "R9"; m_busy_tag = "R9";
      end else begin
        m_oe_tag = "R1";
        if (rd_en) begin
          if (busy) begin
            m_dq = {8'h00, m_b7, m_tog, 6'h00};
            m_dq_tag = m_op_tag; m_stat = 1;
            m_tog = ~m_tog;
          end else begin
            m_dq = arr_f(rd_addr); m_dq_tag = "R2";
          end
        end
        if (busy) begin
          if (prog_start || erase_start) m_busy_tag = "R7";
          if (m_rem == 0) m_mode = 0;
          else m_rem--;
        end else if (prog_start) begin
          m_mode = 1; m_rem = P - 1; m_b7 = ~wr_data[7];
          m_op_tag = erase_start ? "R11" : "R3"; m_busy_tag = "R6";
        end else if (erase_start) begin
          m_mode = 2; m_rem = E - 1; m_b7 = 1'b0;
          m_op_tag = "R4"; m_busy_tag = "R6";
        end
      end
    end
  end

  always @(negedge clk) begin
    if (m_live && !finished) begin
      chk(m_oe_tag, 32'(dq_oe), 32'(m_mode != 3));
      chk(m_busy_tag, 32'(busy_pd), 32'((m_mode == 1) || (m_mode == 2)));
      chk(m_dq_tag, 32'(dq), 32'(m_dq));
      if (m_stat) chk("R5", 32'(dq[6]), 32'(m_dq[6]));
    end
  end

  task automatic cyc(logic rd, logic [18:0] a, logic ps, logic es, logic [15:0] wd, logic fr);
    @(negedge clk);
    rd_en = rd; rd_addr = a; prog_start = ps; erase_start = es; wr_data = wd; frst_n = fr;
    #1;
    chk("R10", 32'(arr_addr), 32'(a));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 19'h0, 1'b0, 1'b0, 16'h0, 1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", 32'(dq_oe), 32'd1);
    chk("R1", 32'(busy_pd), 32'd0);
    chk("R1", 32'(dq), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", 32'(dq_oe), 32'd1);
    chk("R1", 32'(dq), 32'd0);
    m_live = 1;

    // reads in read mode
    cyc(1, 19'h00000, 0, 0, 0, 1);
    cyc(1, 19'h7FFFF, 0, 0, 0, 1);
    cyc(1, 19'h12345, 0, 0, 0, 1);
    idle(3);
    cyc(1, 19'h40001, 0, 0, 0, 1);
    idle(1);

    // program, bit7 of data = 1, poll every cycle
    cyc(0, 0, 1, 0, 16'h80F0, 1);
    for (int i = 0; i < P + 3; i++) cyc(1, 19'(i * 3 + 5), 0, 0, 0, 1);
    idle(2);

    // program, bit7 = 0, poll every other cycle
    cyc(0, 0, 1, 0, 16'h0011, 1);
    for (int i = 0; i < P + 3; i++) cyc(i[0], 19'h0ABC, 0, 0, 0, 1);
    idle(2);

    // erase with polling and ignored starts
    cyc(1, 19'h00100, 0, 1, 0, 1);
    for (int i = 0; i < E + 3; i++)
      cyc(1, 19'h00100, (i == 4), (i == 9), 16'hFFFF, 1);
    idle(2);

    // simultaneous starts: program wins
    cyc(0, 0, 1, 1, 16'h0000, 1);
    for (int i = 0; i < P + 2; i++) cyc(1, 19'h3, 0, 0, 0, 1);
    idle(2);

    // flash reset during program, start at release edge ignored
    cyc(0, 0, 1, 0, 16'h7FFF, 1);
    cyc(1, 19'h1, 0, 0, 0, 1);
    cyc(1, 19'h2, 0, 0, 0, 0);
    cyc(1, 19'h3, 1, 0, 0, 0);
    cyc(1, 19'h4, 0, 1, 0, 0);
    cyc(1, 19'h5, 1, 0, 16'h0080, 1);
    cyc(1, 19'h6, 0, 0, 0, 1);
    @(negedge clk);
    chk("R9", 32'(busy_pd), 32'd0);
    idle(2);

    // flash reset in read mode
    cyc(0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1);
    cyc(1, 19'h55555, 0, 0, 0, 1);
    idle(3);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule